// File: doc/BRIEF.md
# Gated-Input Serial-to-Parallel Shift Register

This block converts a serial bit stream into a parallel word. The bit that enters the register on each rising clock edge is the logical AND of two serial inputs. Either input can therefore act as an enable for the other: while one input is held high, the other input supplies the data. While either input is held low, zeros are shifted in. Every stage is visible at once on a parallel output bus. The last stage is also driven onto a serial output, so several instances can be chained into a longer register.

An active-low clear acts asynchronously. It empties every stage as soon as it is asserted, without waiting for a clock edge, and holds the register empty for as long as it stays low. Normal shifting resumes on the first rising edge after the clear is released. The number of stages is a parameter with a default of eight. Bit 0 of the parallel bus is the entry stage, and the highest bit is the stage that feeds the serial output.

Top module: `gated_sipo`

## Requirements
- R1: When `clr_n` goes low, every bit of `par_q` becomes 0 without any clock edge. This holds even when the clear pulse starts and ends between two rising edges.
- R2: While `clr_n` is low, `par_q` stays all zeros, whatever `clk`, `ser_a` and `ser_b` do.
- R3: On each rising edge of `clk` with `clr_n` high, `par_q[0]` takes the value of `ser_a & ser_b` sampled at that edge.
- R4: If either serial input is low at a rising edge, `par_q[0]` becomes 0, even when the other input is high. If one input is high, `par_q[0]` follows the other input.
- R5: On each rising edge with `clr_n` high, `par_q[i]` takes the old `par_q[i-1]` for every i from 1 to STAGES-1. The old top bit is discarded.
- R6: Without a rising edge of `clk`, `par_q` does not change. This covers a steady clock level, a falling clock edge, and any change on `ser_a` or `ser_b`.
- R7: `ser_out` always equals `par_q[STAGES-1]`. A 1 that enters the register reaches `ser_out` after STAGES rising edges.
- R8: After `clr_n` returns high, the first rising edge shifts normally. Bit 0 takes the gated input and every other bit stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the register moves on the rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| ser_a | input | 1 | First serial input, ANDed with `ser_b` |
| ser_b | input | 1 | Second serial input, ANDed with `ser_a` |
| par_q | output | STAGES | Parallel view of all stages; bit 0 is the entry stage |
| ser_out | output | 1 | Copy of the last stage, for chaining instances |

## Verification
The bound checker checks three things on every rising edge: the entry stage against the gated inputs of the previous edge, each later stage against its neighbour one edge earlier, and the all-zero state while the clear is low or has been pulsed since the last edge. Some behaviour is invisible to an edge-sampled property, and only the bench's scenarios can show it. This covers the register emptying at the instant the clear falls in the middle of a clock phase, the register holding still while the inputs toggle and the clock falls, and the timing of a 1 reaching the serial output.

// File: rtl/gated_sipo_pkg.sv
// Package: shared constants for the gated serial-to-parallel register.
// Assumes: nothing beyond being compiled ahead of the modules that import it.
package gated_sipo_pkg;
    localparam int unsigned DEFAULT_STAGES = 8;
    localparam logic        STAGE_CLEARED  = 1'b0;
endpackage

// File: rtl/sipo_gate.sv
// Module: sipo_gate
// Combines the two serial inputs into the single bit offered to the first
// stage: a low on either input forces a zero, a high passes the other input.
// Assumes: both inputs are stable around the rising clock edge.
module sipo_gate (
    input  logic in_a,
    input  logic in_b,
    output logic gated
);
    // Purpose: AND the serial inputs so either one can gate the other.
    always_comb begin
        gated = in_a & in_b;
    end
endmodule

// File: rtl/sipo_stage.sv
// Module: sipo_stage
// One storage bit of the chain. It loads d on the rising clock edge and
// empties at once while clr_n is low.
// Assumes: clr_n is released away from the rising edge of clk.
module sipo_stage
    import gated_sipo_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic d,
    output logic q
);
    // Purpose: edge-triggered bit with an asynchronous active-low clear.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= STAGE_CLEARED;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/gated_sipo.sv
// Module: gated_sipo
// Serial-in, parallel-out register of STAGES bits. The entry bit is the AND
// of ser_a and ser_b. Each rising edge moves every bit one place towards the
// top. clr_n empties the chain asynchronously. ser_out mirrors the top bit
// so that instances can be chained.
// Assumes: STAGES >= 2.
module gated_sipo
    import gated_sipo_pkg::*;
#(
    parameter int unsigned STAGES = DEFAULT_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              ser_a,
    input  logic              ser_b,
    output logic [STAGES-1:0] par_q,
    output logic              ser_out
);
    localparam int unsigned TOP = STAGES - 1;

    logic              entry_bit;
    logic [STAGES-1:0] stage_d;

    sipo_gate u_gate (
        .in_a  (ser_a),
        .in_b  (ser_b),
        .gated (entry_bit)
    );

    // Purpose: feed each stage from its lower neighbour, stage 0 from the gate.
    always_comb begin
        stage_d = {par_q[TOP-1:0], entry_bit};
    end

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        sipo_stage u_stage (
            .clk   (clk),
            .clr_n (clr_n),
            .d     (stage_d[g]),
            .q     (par_q[g])
        );
    end

    // Purpose: expose the top stage as the chaining output.
    always_comb begin
        ser_out = par_q[TOP];
    end
endmodule

// File: rtl/gated_sipo_chk.sv
// Module: gated_sipo_chk
// Edge-sampled checks for gated_sipo, attached with bind.
// Assumes: it sees the same clk and clr_n as the register it checks.
module gated_sipo_chk #(
    parameter int unsigned STAGES = 8
) (
    input logic              clk,
    input logic              clr_n,
    input logic              ser_a,
    input logic              ser_b,
    input logic [STAGES-1:0] par_q,
    input logic              ser_out
);
    // Purpose: 1 at an edge only if no clear has occurred since the previous edge.
    logic armed;
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            armed <= 1'b0;
        end else begin
            armed <= 1'b1;
        end
    end

    p_entry_r3: assert property (@(posedge clk) disable iff (!clr_n)
        armed |-> (par_q[0] == $past(ser_a & ser_b)))
        else $error("entry stage does not match gated inputs");

    p_shift_r5: assert property (@(posedge clk) disable iff (!clr_n)
        armed |-> (par_q[STAGES-1:1] == $past(par_q[STAGES-2:0])))
        else $error("chain did not advance by one place");

    p_clear_held_r2: assert property (@(posedge clk)
        !clr_n |-> (par_q == '0))
        else $error("register not empty while clear is low");

    p_clear_pulse_r1: assert property (@(posedge clk)
        !armed |-> (par_q == '0))
        else $error("clear since the last edge did not empty the register");
endmodule

bind gated_sipo gated_sipo_chk #(.STAGES(STAGES)) u_chk (
    .clk     (clk),
    .clr_n   (clr_n),
    .ser_a   (ser_a),
    .ser_b   (ser_b),
    .par_q   (par_q),
    .ser_out (ser_out)
);

// File: tb/gated_sipo_tb.sv
// Bench for gated_sipo: a vector table walked by one loop, then directed
// tests and a random run, all compared with a queue model.
module gated_sipo_tb;
    localparam int unsigned W    = 8;
    localparam int unsigned NVEC = 16;

    // Each entry: {ser_a, ser_b}. The expected word comes from the model.
    localparam logic [1:0] VEC [NVEC] = '{
        2'b11, 2'b10, 2'b01, 2'b00, 2'b11, 2'b11, 2'b01, 2'b11,
        2'b10, 2'b11, 2'b00, 2'b11, 2'b11, 2'b11, 2'b10, 2'b01
    };

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         ser_a = 1'b0;
    logic         ser_b = 1'b0;
    logic [W-1:0] par_q;
    logic         ser_out;

    int unsigned  n_vec = 0;
    int unsigned  n_bad = 0;
    logic [W-1:0] model = '0;
    logic [W-1:0] snap;

    always #4 clk = ~clk;

    gated_sipo #(.STAGES(W)) u_dut (
        .clk     (clk),
        .clr_n   (clr_n),
        .ser_a   (ser_a),
        .ser_b   (ser_b),
        .par_q   (par_q),
        .ser_out (ser_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: par_q actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic check_out(input string req);
        n_vec++;
        if (ser_out !== model[W-1]) begin
            n_bad++;
            $display("FAIL %s: ser_out actual %b expected %b", req, ser_out, model[W-1]);
        end
    endtask

    // One shift: drive inputs in the low phase, then check after the rising edge.
    task automatic step(input logic a, input logic b, input string req);
        ser_a = a;
        ser_b = b;
        @(posedge clk);
        model = {model[W-2:0], a & b};
        @(negedge clk);
        check(req, par_q, model);
        check_out("R7");
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #1 clr_n = 1'b0;
        @(negedge clk);
        check("R1 reset state", par_q, '0);
        clr_n = 1'b1;
        model = '0;

        // Table walk: R3 entry, R4 gating, R5 shift
        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][1], VEC[i][0], "R3/R4/R5 table");
        end

        // R6: inputs toggle and the clock falls without a rising edge
        snap = par_q;
        ser_a = ~ser_a; #1 ser_b = ~ser_b; #1 ser_a = ~ser_a;
        #1 check("R6 inputs toggled", par_q, snap);
        @(posedge clk); #1;
        snap = par_q;
        model = par_q;
        @(negedge clk); #1 ser_a = 1'b1; ser_b = 1'b1;
        check("R6 falling edge", par_q, snap);

        // Fill with ones, then clear mid-phase without any edge: R1
        for (int i = 0; i < W; i++) step(1'b1, 1'b1, "R4 fill");
        #1 clr_n = 1'b0;
        #1 check("R1 clear between edges", par_q, '0);
        // R2: held low across edges with inputs high
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R2 clear held", par_q, '0);
        // R8: release in low phase, first edge shifts normally
        clr_n = 1'b1;
        model = '0;
        step(1'b1, 1'b1, "R8 resume");
        check("R8 resume exact", par_q, {{(W-1){1'b0}}, 1'b1});

        // R7: a single 1 reaches ser_out after W edges
        for (int i = 1; i < W; i++) step(1'b0, 1'b1, "R7 walk");
        n_vec++;
        if (ser_out !== 1'b1) begin
            n_bad++;
            $display("FAIL R7: ser_out actual %b expected 1", ser_out);
        end
        step(1'b1, 1'b0, "R4 gate b low");
        n_vec++;
        if (ser_out !== 1'b0) begin
            n_bad++;
            $display("FAIL R7: ser_out actual %b expected 0", ser_out);
        end

        // Random run with occasional clear pulses between edges: R1 R3 R5
        for (int i = 0; i < 300; i++) begin
            if (($urandom % 16) == 0) begin
                #1 clr_n = 1'b0;
                #1 clr_n = 1'b1;
                model = '0;
                check("R1 random pulse", par_q, '0);
            end
            step(1'($urandom), 1'($urandom), "R3/R5 random");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule